// File: doc/BRIEF.md
# Serial Register Access Master

This block lets a processor read and write single-byte registers inside up to three serial peripherals over a four-wire serial link. Software first sets a clock divider in the configuration register. It then writes one 32-bit command word to the transmit register, and that write starts the transfer. The command word carries one chip-select enable per device, an instruction byte, a register address and a data byte. The low 24 bits of the word go out most significant bit first, with the serial clock idling low (mode 0).

Each device has its own serial data return line. During a read, the block captures the byte that each selected device returns in the final byte slot. It then places each byte in its own 8-bit lane of the receive register, so one read command can fetch the same register from several devices at once. The configuration register also shows a busy flag and four external status inputs.

The engine is a four-state machine:
- ST_IDLE waits for a command. On an accepted transmit write it moves to ST_LOW.
- ST_LOW holds the clock low for one half period, then moves to ST_HIGH.
- ST_HIGH holds the clock high for one half period. It returns to ST_LOW for the next bit, or moves to ST_TAIL after bit 24.
- ST_TAIL holds the chip selects for one more half period, then returns to ST_IDLE.

Top module: `spi_regmaster`

Bus map (word address on `bus_addr`):
- 0 is configuration. On write, bits [7:0] set the divider. On read, [31:28] show the status input, [8] shows busy and [7:0] show the divider.
- 1 is transmit. Writing it starts a frame. Reading it returns the last accepted command word.
- 2 is receive, read-only.
- 3 reads as zero.

## Requirements
- R1: After reset, all chip selects are high and the serial clock and data output are low. The busy flag is 0, the receive register is 0, and the divider reads 3.
- R2: A transmit write accepted while idle drives chip select d low when command bit 24+d is 1. The other chip selects stay high, and all of them return high only when the frame ends.
- R3: Command bits [23:0] leave on `mosi`, bit 23 first. A new bit appears only on a falling edge of the serial clock (or at frame start), and the data is steady while the clock is high.
- R4: Each serial clock half period lasts max(div,1)+1 system clocks. The divider value is captured when the frame starts, so a configuration write during a frame does not change that frame.
- R5: The busy bit (configuration bit 8) is set from the clock edge that accepts the command until chip selects rise. Chip selects rise one half period after the 24th falling clock edge, so a frame lasts 49 half periods.
- R6: A transmit write while busy is ignored. The running frame continues unchanged, and the transmit readback keeps the earlier word.
- R7: A command with bit 23 = 1 is a read. Device d's own return line is sampled on each of the last 8 rising clock edges, MSB first. Receive lane d (bits [8d+7:8d]) then holds that byte if device d was selected, and 0 otherwise. Device 0 sits in the least significant lane, and bits [31:24] are 0.
- R8: A command with bit 23 = 0 is a write and leaves the receive register unchanged.
- R9: Configuration readback bits [31:28] follow the external status input.
- R10: A command with no chip-select bit set still runs a full frame with busy set, but every chip select stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| ext_status | input | 4 | External status bits shown in configuration readback |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the devices |
| sdi | input | NUM_DEV | Serial data returned by each device |
| cs_n | output | NUM_DEV | Active-low chip selects |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- Divider values 0 and 1, which must give the same two-cycle half period. A design without the zero clamp would run a one-cycle half period and shift every later edge.
- A divider rewrite in the middle of a frame. A design that does not capture the divider would stretch the remaining half periods.
- A transmit write issued mid-frame and on the last busy cycle. A design that accepts it would restart the chip selects or change the transmit readback.
- Reads with one, two and three devices selected, each returning a different byte. Swapped lanes, unmasked unselected lanes or an off-by-one sampling slot would show up as a wrong receive word.
- A write frame after a read, which must leave the receive word as it was.

// File: rtl/spi_regmaster_pkg.sv
package spi_regmaster_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_TAIL
    } eng_state_t;

    localparam int FRAME_BITS = 24;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam int CAPT_BITS  = 8;
    localparam int CS_LSB     = 24;
    localparam int RNW_BIT    = 23;
    localparam int STAT_LSB   = 28;

    localparam logic [1:0] ADDR_CFG = 2'd0;
    localparam logic [1:0] ADDR_TX  = 2'd1;
    localparam logic [1:0] ADDR_RX  = 2'd2;

endpackage

// File: rtl/spi_regmaster_engine.sv
module spi_regmaster_engine
    import spi_regmaster_pkg::*;
#(
    parameter int NUM_DEV = 3,
    parameter int DIV_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [31:0]        word,
    input  logic [DIV_W-1:0]   div,
    output logic               busy,
    output logic               sclk,
    output logic               mosi,
    output logic [NUM_DEV-1:0] cs_n,
    output logic               sample,
    output logic               done
);
    localparam int CNT_W = DIV_W + 1;
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_BITS - 1);
    localparam logic [BIT_W-1:0] FIRST_CAP = BIT_W'(FRAME_BITS - CAPT_BITS);

    eng_state_t state_q, state_d;
    logic [CNT_W-1:0]      hcnt_q, half_q, half_new;
    logic [BIT_W-1:0]      bit_q;
    logic [FRAME_BITS-1:0] sh_q;
    logic                  tick, last_bit;

    assign tick     = (hcnt_q == half_q - 1'b1);
    assign last_bit = (bit_q == LAST_BIT);
    assign half_new = (div == '0) ? CNT_W'(2) : ({1'b0, div} + 1'b1);

    assign busy   = (state_q != ST_IDLE);
    assign sample = (state_q == ST_LOW) && tick && (bit_q >= FIRST_CAP);
    assign done   = (state_q == ST_TAIL) && tick;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LOW;
            ST_LOW:  if (tick)  state_d = ST_HIGH;
            ST_HIGH: if (tick)  state_d = last_bit ? ST_TAIL : ST_LOW;
            ST_TAIL: if (tick)  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and pin outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt_q <= '0;
            half_q <= CNT_W'(2);
            bit_q  <= '0;
            sh_q   <= '0;
            sclk   <= 1'b0;
            mosi   <= 1'b0;
            cs_n   <= '1;
        end else begin
            if (state_q == ST_IDLE || tick) hcnt_q <= '0;
            else                             hcnt_q <= hcnt_q + 1'b1;

            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        half_q <= half_new;
                        bit_q  <= '0;
                        sh_q   <= word[FRAME_BITS-1:0];
                        mosi   <= word[FRAME_BITS-1];
                        cs_n   <= ~word[CS_LSB +: NUM_DEV];
                    end
                end
                ST_LOW: begin
                    if (tick) sclk <= 1'b1;
                end
                ST_HIGH: begin
                    if (tick) begin
                        sclk <= 1'b0;
                        if (!last_bit) begin
                            bit_q <= bit_q + 1'b1;
                            sh_q  <= sh_q << 1;
                            mosi  <= sh_q[FRAME_BITS-2];
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) cs_n <= '1;
                end
            endcase
        end
    end
endmodule

// File: rtl/spi_regmaster_capture.sv
module spi_regmaster_capture
    import spi_regmaster_pkg::*;
#(
    parameter int NUM_DEV = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sample,
    input  logic [NUM_DEV-1:0]            sdi,
    output logic [NUM_DEV*CAPT_BITS-1:0]  bytes
);
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_lane
        logic [CAPT_BITS-1:0] sh_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sh_q <= '0;
            else if (sample) sh_q <= {sh_q[CAPT_BITS-2:0], sdi[d]};
        end
        assign bytes[d*CAPT_BITS +: CAPT_BITS] = sh_q;
    end
endmodule

// File: rtl/spi_regmaster_regs.sv
module spi_regmaster_regs
    import spi_regmaster_pkg::*;
#(
    parameter int NUM_DEV = 3,
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic [1:0]                   bus_addr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    input  logic [3:0]                   ext_status,
    input  logic                         busy,
    input  logic                         done,
    input  logic [NUM_DEV*CAPT_BITS-1:0] capt,
    output logic [DIV_W-1:0]             div_q,
    output logic                         start
);
    logic [31:0] tx_q, rx_q, rx_d, cfg_rd;

    assign start = bus_wr && (bus_addr == ADDR_TX) && !busy;

    always_comb begin
        rx_d = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (tx_q[CS_LSB + d]) rx_d[d*CAPT_BITS +: CAPT_BITS] = capt[d*CAPT_BITS +: CAPT_BITS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= DIV_W'(DIV_RST);
            tx_q  <= '0;
            rx_q  <= '0;
        end else begin
            if (bus_wr && bus_addr == ADDR_CFG) div_q <= bus_wdata[DIV_W-1:0];
            if (start) tx_q <= bus_wdata;
            if (done && tx_q[RNW_BIT]) rx_q <= rx_d;
        end
    end

    always_comb begin
        cfg_rd = '0;
        cfg_rd[DIV_W-1:0]          = div_q;
        cfg_rd[DIV_W]              = busy;
        cfg_rd[STAT_LSB +: 4]      = ext_status;
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CFG: bus_rdata = cfg_rd;
            ADDR_TX:  bus_rdata = tx_q;
            ADDR_RX:  bus_rdata = rx_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
    import spi_regmaster_pkg::*;
#(
    parameter int NUM_DEV = 3,
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [1:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [3:0]         ext_status,
    output logic               sclk,
    output logic               mosi,
    input  logic [NUM_DEV-1:0] sdi,
    output logic [NUM_DEV-1:0] cs_n
);
    logic                         busy_w, start_w, sample_w, done_w;
    logic [DIV_W-1:0]             div_w;
    logic [NUM_DEV*CAPT_BITS-1:0] capt_w;

    spi_regmaster_regs #(.NUM_DEV(NUM_DEV), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_status(ext_status),
        .busy(busy_w), .done(done_w), .capt(capt_w), .div_q(div_w), .start(start_w)
    );

    spi_regmaster_engine #(.NUM_DEV(NUM_DEV), .DIV_W(DIV_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start_w), .word(bus_wdata), .div(div_w),
        .busy(busy_w), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
        .sample(sample_w), .done(done_w)
    );

    spi_regmaster_capture #(.NUM_DEV(NUM_DEV)) u_capt (
        .clk(clk), .rst_n(rst_n), .sample(sample_w), .sdi(sdi), .bytes(capt_w)
    );
endmodule

// File: rtl/spi_regmaster_chk.sv
module spi_regmaster_chk #(
    parameter int NUM_DEV = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sclk,
    input logic               mosi,
    input logic [NUM_DEV-1:0] cs_n,
    input logic               busy
);
    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R4
    sclk_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> busy);

    // R5
    idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&cs_n));

    // R2
    cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_n) |-> (!sclk && !$past(sclk)));

    // R2
    cs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cs_n) && !(&cs_n)) |-> (busy && !$past(busy)));

    // R5
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (&cs_n));
endmodule

bind spi_regmaster spi_regmaster_chk #(.NUM_DEV(NUM_DEV)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy_w)
);

// File: tb/spi_regmaster_test.sv
`timescale 1ns/1ps
module spi_regmaster_test;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [3:0]   ext_status = 4'b1010;
    logic         sclk, mosi;
    logic [N-1:0] sdi = '1;
    logic [N-1:0] cs_n;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference model state
    bit          m_act = 0;
    int          m_k = 0;
    int          m_h = 4;
    logic [7:0]  m_div = 8'd3;
    logic [31:0] m_tx = '0;
    logic [31:0] m_rx = '0;
    logic        m_mosi = 1'b0;
    logic [7:0]  dev_byte [N];

    always #10 clk = ~clk;

    spi_regmaster #(.NUM_DEV(N)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_status(ext_status),
        .sclk(sclk), .mosi(mosi), .sdi(sdi), .cs_n(cs_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rdata(input logic [1:0] a);
        logic [31:0] v;
        v = '0;
        case (a)
            2'd0: begin v[7:0] = m_div; v[8] = m_act; v[31:28] = ext_status; end
            2'd1: v = m_tx;
            2'd2: v = m_rx;
            default: v = '0;
        endcase
        return v;
    endfunction

    // one system clock: drive device data, model the edge, compare at negedge
    task automatic step();
        int i;
        bit was_act;
        logic [N-1:0] s;
        s = '1;
        if (m_act && m_k < 48*m_h) begin
            i = m_k / (2*m_h);
            if (i >= 16) for (int d = 0; d < N; d++) s[d] = dev_byte[d][23-i];
        end
        sdi = s;
        @(posedge clk);
        was_act = m_act;
        if (bus_wr && bus_addr == 2'd0) m_div = bus_wdata[7:0];
        if (m_act) begin
            m_k++;
            if (m_k == 49*m_h) begin
                m_act = 0;
                if (m_tx[23]) begin
                    m_rx = '0;
                    for (int d = 0; d < N; d++) if (m_tx[24+d]) m_rx[8*d +: 8] = dev_byte[d];
                end
            end
        end
        if (!was_act && bus_wr && bus_addr == 2'd1) begin
            m_tx  = bus_wdata;
            m_act = 1;
            m_k   = 0;
            m_h   = ((m_div == 0) ? 1 : int'(m_div)) + 1;
        end
        if (m_act) m_mosi = (m_k < 48*m_h) ? m_tx[23 - m_k/(2*m_h)] : m_tx[0];
        @(negedge clk);
        chk("R2 cs_n", {29'd0, cs_n}, m_act ? {29'd0, ~m_tx[26:24]} : 32'h7);
        chk("R4 sclk", {31'd0, sclk},
            {31'd0, (m_act && m_k < 48*m_h && ((m_k/m_h) % 2 == 1))});
        chk("R3 mosi", {31'd0, mosi}, {31'd0, m_mosi});
        chk("R5 rdata", bus_rdata, exp_rdata(bus_addr));
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0; bus_addr = 2'd0;
    endtask

    task automatic bus_read(input string tag, input logic [1:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        bus_addr = 2'd0;
    endtask

    task automatic run_out();
        while (m_act) step();
        step();
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        dev_byte[0] = 8'h10; dev_byte[1] = 8'h33; dev_byte[2] = 8'hE7;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cs_n", {29'd0, cs_n}, 32'h7);
        chk("R1 sclk", {31'd0, sclk}, 32'd0);
        chk("R1 mosi", {31'd0, mosi}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read("R1 cfg", 2'd0, 32'hA000_0003);
        bus_read("R1 rx", 2'd2, 32'd0);
        // R9 status follows input
        ext_status = 4'b0101; #1;
        bus_read("R9 status", 2'd0, 32'h5000_0003);

        // write frame, device 0, divider 3
        bus_write(2'd1, 32'h0100_4A5C);
        repeat (20) step();
        // R6 write while busy ignored
        bus_write(2'd1, 32'h0700_FFFF);
        bus_read("R6 tx readback", 2'd1, 32'h0100_4A5C);
        run_out();
        bus_read("R8 rx after write", 2'd2, 32'd0);

        // read from devices 0 and 1
        bus_write(2'd1, 32'h0380_0000);
        run_out();
        bus_read("R7 two lanes", 2'd2, 32'h0000_3310);

        // divider 0 behaves as 1, write frame keeps rx
        bus_write(2'd0, 32'h0);
        bus_write(2'd1, 32'h0400_51A5);
        run_out();
        bus_read("R8 rx kept", 2'd2, 32'h0000_3310);

        // divider 1, read device 2 only
        bus_write(2'd0, 32'h1);
        bus_write(2'd1, 32'h0480_4A00);
        run_out();
        bus_read("R7 lane 2", 2'd2, 32'h00E7_0000);

        // R4 divider rewrite mid-frame leaves frame timing alone
        bus_write(2'd0, 32'h2);
        bus_write(2'd1, 32'h0280_0100);
        repeat (10) step();
        bus_write(2'd0, 32'h7);
        run_out();
        bus_read("R4 lane 1", 2'd2, 32'h0000_3300);

        // R10 no chip select
        bus_write(2'd0, 32'h0);
        bus_write(2'd1, 32'h0000_1234);
        repeat (5) step();
        chk("R10 cs_n idle", {29'd0, cs_n}, 32'h7);
        bus_read("R10 busy", 2'd0, 32'h5000_0100);
        run_out();

        // R6 write on last busy cycle is ignored
        dev_byte[0] = 8'hA5; dev_byte[1] = 8'h5A; dev_byte[2] = 8'hC3;
        bus_write(2'd0, 32'h5);
        bus_write(2'd1, 32'h0780_3C00);
        while (!(m_act && m_k == 49*m_h - 1)) step();
        bus_write(2'd1, 32'h0100_0000);
        bus_read("R6 tail write", 2'd1, 32'h0780_3C00);
        step();
        bus_read("R7 three lanes", 2'd2, 32'h00C3_5AA5);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule